// File: doc/BRIEF.md
# Synthesizer Divider Configuration Port

This block keeps the live configuration words of a clock synthesizer: a 9-bit feedback divide value, a 2-bit output divide code and a 3-bit test-select code. It can be set either from a bank of parallel pins or over a three-wire serial link, and both paths write the same set of active registers. The parallel path is gated by an active-low strobe. While that strobe is low, the active divide values track the pins. The rising edge of the strobe freezes them.

The serial path is a 14-bit shift register. A separate serial load strobe moves its contents into the active registers on its rising edge and freezes them on its falling edge. While the serial load strobe stays high, every serial clock edge passes the newly shifted word straight to the active values. The most significant shift bit is driven out, so a word that has been shifted in can be read back.

All pins are asynchronous. Each one passes through a synchronizer clocked by one fast system clock, and the block then detects edges on the synchronized values. The system clock must run at least four times faster than the serial clock.

Top module: `synth_cfg_port`

## Requirements
- R1: After reset the active feedback value is 511 (all ones), the output divide code is 3 (all ones), the test-select code is 0 and the shift register holds zero, so the readback bit is 0.
- R2: While the parallel strobe is low, the active feedback and output divide values follow the parallel pins, and the test-select code is 0.
- R3: A rising edge of the parallel strobe keeps the pin values. After that, changes on the pins have no effect while the parallel strobe is high and no serial load occurs.
- R4: With the parallel strobe high, each rising serial clock edge shifts the serial data bit into bit 0 of the 14-bit shift register. A frame is sent most significant bit first. Bits 13..11 are the test-select code, bits 10..9 are the output divide code and bits 8..0 are the feedback value, so the feedback LSB is the last bit sent.
- R5: With the parallel strobe high, a rising edge of the serial load strobe copies the three fields of the shift register into the active values.
- R6: A falling edge of the serial load strobe freezes the active values. Later shifting with the serial load strobe low leaves them unchanged.
- R7: While the serial load strobe is held high, each rising serial clock edge copies the newly shifted register contents to the active values.
- R8: The readback output is bit 13 of the shift register.
- R9: When a serial clock rise and a serial load rise are seen in the same system cycle, the shift happens first and the shifted word is the one that is copied.
- R10: Serial clock edges while the parallel strobe is low do not change the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pLoadN | input | 1 | Active-low parallel load strobe |
| mPins | input | 9 | Parallel feedback divide value |
| nPins | input | 2 | Parallel output divide code |
| sClk | input | 1 | Serial clock, sampled for its rising edge |
| sData | input | 1 | Serial data |
| sLoad | input | 1 | Serial load strobe |
| mActive | output | 9 | Active feedback divide value |
| nActive | output | 2 | Active output divide code |
| tActive | output | 3 | Active test-select code |
| sOut | output | 1 | Serial readback bit |

## Verification
Two serial functions can fall in the same system cycle: a shift and a serial load. This happens when a serial clock rise and a serial load rise arrive together, or when the load strobe is held high across a clock edge. The bench provokes the first case by raising both pins in the same instant, so that both pass through synchronizers of equal depth and land in one cycle. The scoreboard then expects the active values to contain the newly shifted bit, not the word that was there before the shift. The held-high case is judged the same way, one shift at a time, against a model shift register kept in the bench.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 3;
  localparam int FRAME_W = T_W + N_W + M_W;
  localparam int M_LSB   = 0;
  localparam int N_LSB   = M_W;
  localparam int T_LSB   = M_W + N_W;

  typedef struct packed {
    logic shiftEn;   // shift one serial bit in this cycle
    logic loadPins;  // copy parallel pins into active values
    logic loadShift; // copy (possibly just-shifted) frame into active values
  } cfgStrobe_t;
endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/synth_cfg_ctrl.sv
module synth_cfg_ctrl
  import synth_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pLoadNSync,
  input  logic       sClkSync,
  input  logic       sLoadSync,
  output cfgStrobe_t strobe
);
  logic pLoadPrev, sClkPrev, sLoadPrev;
  logic pRise, sClkRise, sLoadRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pLoadPrev <= 1'b1;
      sClkPrev  <= 1'b0;
      sLoadPrev <= 1'b0;
    end else begin
      pLoadPrev <= pLoadNSync;
      sClkPrev  <= sClkSync;
      sLoadPrev <= sLoadSync;
    end
  end

  assign pRise     = pLoadNSync & ~pLoadPrev;
  assign sClkRise  = sClkSync & ~sClkPrev;
  assign sLoadRise = sLoadSync & ~sLoadPrev;

  always_comb begin
    strobe           = '0;
    strobe.shiftEn   = pLoadNSync & sClkRise;
    strobe.loadPins  = ~pLoadNSync | pRise;
    strobe.loadShift = pLoadNSync & ~pRise & (sLoadRise | (sLoadSync & sClkRise));
  end

  // R10
  pin_mode_no_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pLoadNSync |-> !strobe.shiftEn && !strobe.loadShift);
endmodule

// File: rtl/synth_cfg_datapath.sv
module synth_cfg_datapath
  import synth_cfg_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  cfgStrobe_t     strobe,
  input  logic           sDataSync,
  input  logic [M_W-1:0] mPinsSync,
  input  logic [N_W-1:0] nPinsSync,
  output logic [M_W-1:0] mActive,
  output logic [N_W-1:0] nActive,
  output logic [T_W-1:0] tActive,
  output logic           sOut
);
  logic [FRAME_W-1:0] shiftReg, shiftNext, srcFrame;

  assign shiftNext = {shiftReg[FRAME_W-2:0], sDataSync};
  assign srcFrame  = strobe.shiftEn ? shiftNext : shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= shiftNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mActive <= '1;
      nActive <= '1;
      tActive <= '0;
    end else if (strobe.loadPins) begin
      mActive <= mPinsSync;
      nActive <= nPinsSync;
      tActive <= '0;
    end else if (strobe.loadShift) begin
      mActive <= srcFrame[M_LSB +: M_W];
      nActive <= srcFrame[N_LSB +: N_W];
      tActive <= srcFrame[T_LSB +: T_W];
    end
  end

  assign sOut = shiftReg[FRAME_W-1];

  // R2
  pin_mode_test_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPins |=> tActive == '0);
  // R4
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> $stable(shiftReg));
  // R6
  active_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadPins && !strobe.loadShift |=> $stable({mActive, nActive, tActive}));
  // R8
  readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> sOut == $past(shiftReg[FRAME_W-2]));
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pLoadN,
  input  logic [8:0] mPins,
  input  logic [1:0] nPins,
  input  logic       sClk,
  input  logic       sData,
  input  logic       sLoad,
  output logic [8:0] mActive,
  output logic [1:0] nActive,
  output logic [2:0] tActive,
  output logic       sOut
);
  localparam int DATA_W = 1 + M_W + N_W;

  logic [2:0]        ctlSync;
  logic [DATA_W-1:0] dataSync;
  cfgStrobe_t        strobe;

  synth_cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) uSyncCtl (
    .clk(clk), .rstN(rstN), .din({pLoadN, sClk, sLoad}), .dout(ctlSync));

  synth_cfg_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) uSyncData (
    .clk(clk), .rstN(rstN), .din({sData, mPins, nPins}), .dout(dataSync));

  synth_cfg_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .pLoadNSync(ctlSync[2]), .sClkSync(ctlSync[1]), .sLoadSync(ctlSync[0]),
    .strobe(strobe));

  synth_cfg_datapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .sDataSync(dataSync[DATA_W-1]),
    .mPinsSync(dataSync[N_W +: M_W]),
    .nPinsSync(dataSync[0 +: N_W]),
    .mActive(mActive), .nActive(nActive), .tActive(tActive), .sOut(sOut));
endmodule

// File: tb/synth_cfg_port_test.sv
module synth_cfg_port_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pLoadN = 1'b1, sClk = 1'b0, sData = 1'b0, sLoad = 1'b0;
  logic [8:0] mPins = '0;
  logic [1:0] nPins = '0;
  logic [8:0] mActive;
  logic [1:0] nActive;
  logic [2:0] tActive;
  logic sOut;

  always #5 clk = ~clk;

  synth_cfg_port uut (.*);

  typedef struct {
    logic [8:0] m;
    logic [1:0] n;
    logic [2:0] t;
    logic       so;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0, fails = 0;
  bit done = 0;
  logic [13:0] model = '0;
  logic [8:0] expM = '1;
  logic [1:0] expN = '1;
  logic [2:0] expT = '0;

  // monitor: pops expected items and compares with outputs
  initial forever begin
    @(negedge clk);
    while (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (mActive !== it.m || nActive !== it.n || tActive !== it.t || sOut !== it.so) begin
        fails++;
        $display("FAIL %s: got m=%0d n=%0d t=%0d so=%b, expected m=%0d n=%0d t=%0d so=%b",
                 it.tag, mActive, nActive, tActive, sOut, it.m, it.n, it.t, it.so);
      end
    end
  end

  task automatic expectNow(input string tag);
    expItem_t it;
    repeat (6) @(negedge clk);
    it.m = expM; it.n = expN; it.t = expT; it.so = model[13]; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic takeModel();
    expT = model[13:11]; expN = model[10:9]; expM = model[8:0];
  endtask

  task automatic setPins(input logic [8:0] m, input logic [1:0] n);
    mPins = m; nPins = n;
    if (!pLoadN) begin expM = m; expN = n; expT = 0; end
  endtask

  task automatic setPLoad(input logic v);
    pLoadN = v;
    expM = mPins; expN = nPins; expT = 0; // low: transparent; rising: capture
  endtask

  task automatic serialBit(input logic b);
    sData = b;
    repeat (4) @(negedge clk);
    sClk = 1'b1;
    if (pLoadN) begin
      model = {model[12:0], b};
      if (sLoad) takeModel();
    end
    repeat (4) @(negedge clk);
    sClk = 1'b0;
  endtask

  task automatic sendFrame(input logic [13:0] f);
    for (int i = 13; i >= 0; i--) serialBit(f[i]);
  endtask

  task automatic raiseLoad();
    sLoad = 1'b1;
    if (pLoadN) takeModel();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    expectNow("R1 reset values");

    setPLoad(1'b0); setPins(9'd300, 2'd1);
    expectNow("R2 pins pass through");
    setPins(9'd400, 2'd2);
    expectNow("R2 pins follow change");

    setPLoad(1'b1);
    expectNow("R3 capture on rise");
    setPins(9'd77, 2'd0);
    expectNow("R3 pins ignored after capture");

    sendFrame({3'd5, 2'd2, 9'd257});
    expectNow("R4 R8 shift, active unchanged, readback MSB");

    raiseLoad();
    expectNow("R5 serial load copies frame");

    sLoad = 1'b0;
    expectNow("R6 falling load latches");
    sendFrame({3'd2, 2'd1, 9'd300});
    expectNow("R6 shifting after latch leaves active");

    raiseLoad();
    expectNow("R5 second frame loaded");
    serialBit(1'b1);
    expectNow("R7 held load passes shift 1");
    serialBit(1'b0);
    expectNow("R7 held load passes shift 2");
    sLoad = 1'b0;
    repeat (4) @(negedge clk);

    setPLoad(1'b0);
    expectNow("R2 test code forced zero");
    serialBit(1'b1); serialBit(1'b1); serialBit(1'b0);
    expectNow("R10 readback unchanged in pin mode");
    setPLoad(1'b1);
    repeat (4) @(negedge clk);
    raiseLoad();
    expectNow("R10 shift register intact");
    sLoad = 1'b0;
    repeat (4) @(negedge clk);

    // R9: shift and load rise in one cycle
    sData = 1'b1;
    repeat (4) @(negedge clk);
    sClk = 1'b1; sLoad = 1'b1;
    model = {model[12:0], 1'b1};
    takeModel();
    expectNow("R9 coincident shift and load");
    sClk = 1'b0; sLoad = 1'b0;
    expectNow("R9 values held after release");

    while (expQ.size() > 0) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule